// File: doc/BRIEF.md
# Synthesizer Serial Programming Port

This block is the digital programming port of a frequency synthesizer. A host drives three wires: a serial clock, a data line and a latch strobe. While the strobe is low, each rising serial-clock edge pushes one data bit into a 20-bit shift register, with the most significant bit sent first. On the rising edge of the strobe, the two lowest bits of the shifted word are decoded as a target address. The remaining 18 payload bits are copied into one of three held registers: the reference divider, the main divider (swallow and program counts), or the operating-mode word.

The three serial wires are sampled by the block's system clock and are assumed to be synchronous to it, with each level held for at least one system-clock period. The port also decodes the synthesizer power state. The synthesizer enable is the mode word's enable bit ANDed with the OR of two external power pins, and receive and transmit enables are decoded from the same pins. Register contents survive any power-down, and the serial port keeps working while the synthesizer is disabled. A read-back output presents the oldest bit held in the shift register.

Top module: `synth_prog_port`

## Requirements
- R1: While `lat_en` is low, a rising edge on `ser_clk` shifts `ser_dat` into the shift register at the least significant end, so the first bit sent ends up as word bit 19.
- R2: Rising `ser_clk` edges that occur while `lat_en` is high change neither the shift register nor any held register.
- R3: The held registers change only in the system-clock cycle in which a rising `lat_en` edge is sampled, and they hold their values at all other times.
- R4: Address code 00 (word bits 1:0) loads `ref_div` from word bits 16:2.
- R5: Address code 10 loads `swallow_cnt` from word bits 8:2 and `prog_cnt` from word bits 19:9.
- R6: Address code 01 loads `mode_word` from word bits 19:2. Bit 0 of `mode_word` (word bit 2) is the PLL enable.
- R7: Address code 11 discards the word and leaves every held register unchanged.
- R8: A strobe that follows fewer or more than 20 serial edges transfers the last 20 bits shifted in. When fewer than 20 new bits were sent, the oldest positions are filled by bits from before the new ones.
- R9: `synth_en` equals `mode_word[0]` AND (`pwr_a` OR `pwr_b`). It is combinational in the pins.
- R10: `rx_en` is high only for `pwr_a`=1 with `pwr_b`=0, and `tx_en` is high only for `pwr_a`=0 with `pwr_b`=1. Both also require `mode_word[0]`=1, and the two are never high together.
- R11: When the synthesizer is disabled, register contents are kept, and words written while `mode_word[0]`=0 are still accepted.
- R12: A synchronous active-low reset clears the shift register and all held registers, so every output starts at zero.
- R13: `ser_out` equals shift-register bit 19. After a full 20-bit word has been shifted, it shows that word's first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial wires |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| lat_en | input | 1 | Latch strobe; low allows shifting, a rising edge transfers the word |
| pwr_a | input | 1 | External power pin A (receive select) |
| pwr_b | input | 1 | External power pin B (transmit select) |
| ref_div | output | 15 | Reference divider value |
| swallow_cnt | output | 7 | Swallow count of the main divider |
| prog_cnt | output | 11 | Program count of the main divider |
| mode_word | output | 18 | Operating-mode word; bit 0 is the PLL enable |
| synth_en | output | 1 | Synthesizer enable |
| rx_en | output | 1 | Receive state enable |
| tx_en | output | 1 | Transmit state enable |
| ser_out | output | 1 | Read-back: most significant bit of the shift register |

## Verification
A serial edge or strobe edge on the input pins is acted on at the first system-clock edge that samples the new level. Its effect on `ser_out` or on the held registers can be seen just after that same edge. The power outputs follow the pins in the same cycle, with no register in the path. The reference model applies each input at the rising clock edge and compares every output 3 ns later. Scripted scenario checks are taken only after the strobe has been high for several cycles, so each of them samples a result that is already due and settled.

// File: rtl/sp_pkg.sv
// Shared constants and types for the synthesizer programming port.
// Assumes: a 20-bit serial word whose two lowest bits carry the target address.
package sp_pkg;
    localparam int WORD_W = 20;
    localparam int ADDR_W = 2;
    localparam int REF_W  = 15;
    localparam int SWAL_W = 7;
    localparam int PROG_W = 11;

    typedef enum logic [ADDR_W-1:0] {
        SEL_REF  = 2'b00,
        SEL_MODE = 2'b01,
        SEL_MAIN = 2'b10,
        SEL_NONE = 2'b11
    } sp_sel_e;
endpackage

// File: rtl/sp_serial_shift.sv
// Serial front end: finds rising edges of the serial clock and strobe,
// shifts data while the strobe is low, and flags the transfer moment.
// Assumes the serial wires are synchronous to clk and held for at least one clk period.
module sp_serial_shift #(
    parameter int WORD_W = sp_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              lat_en,
    output logic [WORD_W-1:0] word,
    output logic              load_stb,
    output logic              msb_out
);
    logic sclk_d;
    logic lat_d;
    logic sclk_rise;

    assign sclk_rise = ser_clk && !sclk_d;
    assign load_stb  = lat_en && !lat_d;
    assign msb_out   = word[WORD_W-1];

    // Purpose: remember the previous level of each serial wire for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b1;
            lat_d  <= 1'b1;
        end else begin
            sclk_d <= ser_clk;
            lat_d  <= lat_en;
        end
    end

    // Purpose: shift one bit in at each serial rising edge while the strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (sclk_rise && !lat_en) begin
            word <= {word[WORD_W-2:0], ser_dat};
        end
    end
endmodule

// File: rtl/sp_reg_bank.sv
// Held configuration registers: on a load strobe, decodes the address field
// and copies the payload into the reference, main-divider or mode register.
// Assumes load_stb is a single-cycle pulse and word is stable in that cycle.
module sp_reg_bank #(
    parameter int WORD_W = sp_pkg::WORD_W,
    parameter int ADDR_W = sp_pkg::ADDR_W,
    parameter int REF_W  = sp_pkg::REF_W,
    parameter int SWAL_W = sp_pkg::SWAL_W,
    parameter int PROG_W = sp_pkg::PROG_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_stb,
    input  logic [WORD_W-1:0]        word,
    output logic [REF_W-1:0]         ref_div,
    output logic [SWAL_W-1:0]        swallow_cnt,
    output logic [PROG_W-1:0]        prog_cnt,
    output logic [WORD_W-ADDR_W-1:0] mode_word
);
    import sp_pkg::*;

    localparam int PAY_W = WORD_W - ADDR_W;

    logic [PAY_W-1:0] payload;
    sp_sel_e          sel;

    assign payload = word[WORD_W-1:ADDR_W];
    assign sel     = sp_sel_e'(word[ADDR_W-1:0]);

    // Purpose: load the reference divider on an address-00 transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ref_div <= '0;
        else if (load_stb && sel == SEL_REF) ref_div <= payload[REF_W-1:0];
    end

    // Purpose: load swallow and program counts on an address-10 transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swallow_cnt <= '0;
            prog_cnt    <= '0;
        end else if (load_stb && sel == SEL_MAIN) begin
            swallow_cnt <= payload[SWAL_W-1:0];
            prog_cnt    <= payload[SWAL_W+PROG_W-1:SWAL_W];
        end
    end

    // Purpose: load the operating-mode word on an address-01 transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                           mode_word <= '0;
        else if (load_stb && sel == SEL_MODE) mode_word <= payload;
    end
endmodule

// File: rtl/sp_power.sv
// Power-state decode: gates the synthesizer with the stored enable bit and
// the two external power pins, and derives receive and transmit enables.
// Assumes pins are already synchronous; the decode is purely combinational.
module sp_power (
    input  logic pll_pe,
    input  logic pwr_a,
    input  logic pwr_b,
    output logic synth_en,
    output logic rx_en,
    output logic tx_en
);
    // Purpose: combine enable bit and pins into the three state outputs.
    always_comb begin
        synth_en = pll_pe && (pwr_a || pwr_b);
        rx_en    = pll_pe && pwr_a && !pwr_b;
        tx_en    = pll_pe && !pwr_a && pwr_b;
    end
endmodule

// File: rtl/synth_prog_port.sv
// Top of the synthesizer programming port: serial front end, register bank
// and power decode. Assumes the serial wires are synchronous to clk.
module synth_prog_port #(
    parameter int WORD_W = sp_pkg::WORD_W,
    parameter int ADDR_W = sp_pkg::ADDR_W,
    parameter int REF_W  = sp_pkg::REF_W,
    parameter int SWAL_W = sp_pkg::SWAL_W,
    parameter int PROG_W = sp_pkg::PROG_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_dat,
    input  logic                     lat_en,
    input  logic                     pwr_a,
    input  logic                     pwr_b,
    output logic [REF_W-1:0]         ref_div,
    output logic [SWAL_W-1:0]        swallow_cnt,
    output logic [PROG_W-1:0]        prog_cnt,
    output logic [WORD_W-ADDR_W-1:0] mode_word,
    output logic                     synth_en,
    output logic                     rx_en,
    output logic                     tx_en,
    output logic                     ser_out
);
    logic [WORD_W-1:0] word;
    logic              load_stb;

    sp_serial_shift #(.WORD_W(WORD_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_dat  (ser_dat),
        .lat_en   (lat_en),
        .word     (word),
        .load_stb (load_stb),
        .msb_out  (ser_out)
    );

    sp_reg_bank #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .REF_W(REF_W),
        .SWAL_W(SWAL_W), .PROG_W(PROG_W)
    ) bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_stb    (load_stb),
        .word        (word),
        .ref_div     (ref_div),
        .swallow_cnt (swallow_cnt),
        .prog_cnt    (prog_cnt),
        .mode_word   (mode_word)
    );

    sp_power power_i (
        .pll_pe   (mode_word[0]),
        .pwr_a    (pwr_a),
        .pwr_b    (pwr_b),
        .synth_en (synth_en),
        .rx_en    (rx_en),
        .tx_en    (tx_en)
    );
endmodule

// File: rtl/sp_port_checker.sv
// Property checker for the programming port, attached to the top by bind.
// Assumes the same clock and synchronous active-low reset as the top.
module sp_port_checker #(
    parameter int WORD_W = sp_pkg::WORD_W,
    parameter int ADDR_W = sp_pkg::ADDR_W,
    parameter int REF_W  = sp_pkg::REF_W,
    parameter int SWAL_W = sp_pkg::SWAL_W,
    parameter int PROG_W = sp_pkg::PROG_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     lat_en,
    input logic                     pwr_a,
    input logic                     pwr_b,
    input logic [REF_W-1:0]         ref_div,
    input logic [SWAL_W-1:0]        swallow_cnt,
    input logic [PROG_W-1:0]        prog_cnt,
    input logic [WORD_W-ADDR_W-1:0] mode_word,
    input logic                     synth_en,
    input logic                     rx_en,
    input logic                     tx_en,
    input logic                     ser_out
);
    // R3: without a strobe rising edge the held registers keep their values.
    a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(lat_en && !$past(lat_en)) |=> $stable({ref_div, swallow_cnt, prog_cnt, mode_word}));

    // R10: receive and transmit are never enabled together.
    a_r10_rx_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_en, tx_en}));

    // R10: a receive or transmit state implies the synthesizer is running.
    a_r10_state_needs_synth: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en || tx_en) |-> synth_en);

    // R9: with both pins low the synthesizer is off regardless of the enable bit.
    a_r9_pins_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_a && !pwr_b) |-> !synth_en);

    // R12: right after reset every held register and the read-back are zero.
    a_r12_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ref_div == '0 && swallow_cnt == '0 && prog_cnt == '0
                          && mode_word == '0 && !ser_out));
endmodule

bind synth_prog_port sp_port_checker #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .REF_W(REF_W),
    .SWAL_W(SWAL_W), .PROG_W(PROG_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lat_en      (lat_en),
    .pwr_a       (pwr_a),
    .pwr_b       (pwr_b),
    .ref_div     (ref_div),
    .swallow_cnt (swallow_cnt),
    .prog_cnt    (prog_cnt),
    .mode_word   (mode_word),
    .synth_en    (synth_en),
    .rx_en       (rx_en),
    .tx_en       (tx_en),
    .ser_out     (ser_out)
);

// File: tb/synth_prog_port_tb_top.sv
// Bench for the programming port: a behavioural bit-queue model compared on
// every clock, plus scripted scenario checks with hand-derived values.
module synth_prog_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic lat_en = 1'b0;
    logic pwr_a = 1'b0;
    logic pwr_b = 1'b0;
    logic [14:0] ref_div;
    logic [6:0]  swallow_cnt;
    logic [10:0] prog_cnt;
    logic [17:0] mode_word;
    logic synth_en, rx_en, tx_en, ser_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    synth_prog_port dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .lat_en(lat_en), .pwr_a(pwr_a), .pwr_b(pwr_b),
        .ref_div(ref_div), .swallow_cnt(swallow_cnt), .prog_cnt(prog_cnt),
        .mode_word(mode_word), .synth_en(synth_en), .rx_en(rx_en),
        .tx_en(tx_en), .ser_out(ser_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    bit   mq[$];
    logic m_sclk_prev = 1'b1, m_lat_prev = 1'b1;
    logic [14:0] m_ref;
    logic [6:0]  m_swal;
    logic [10:0] m_prog;
    logic [17:0] m_mode;

    function automatic logic [19:0] model_word();
        logic [19:0] w = '0;
        for (int i = 0; i < 20; i++) w[19-i] = mq[i];
        return w;
    endfunction

    always @(posedge clk) begin
        logic [19:0] w;
        if (!rst_n) begin
            mq.delete();
            for (int i = 0; i < 20; i++) mq.push_back(1'b0);
            m_ref = '0; m_swal = '0; m_prog = '0; m_mode = '0;
            m_sclk_prev = 1'b1; m_lat_prev = 1'b1;
        end else begin
            if (lat_en && !m_lat_prev) begin
                w = model_word();
                if (w[1:0] == 2'd0) m_ref = w[16:2];
                else if (w[1:0] == 2'd2) begin m_swal = w[8:2]; m_prog = w[19:9]; end
                else if (w[1:0] == 2'd1) m_mode = w[19:2];
            end
            if (ser_clk && !m_sclk_prev && !lat_en) begin
                mq.push_back(ser_dat);
                void'(mq.pop_front());
            end
            m_sclk_prev = ser_clk;
            m_lat_prev  = lat_en;
        end
    end

    // Per-clock comparison, 3 ns after the edge.
    always @(posedge clk) begin
        #3;
        if (rst_n && !finished) begin
            check("R4 ref_div model", ref_div, m_ref);
            check("R5 swallow model", swallow_cnt, m_swal);
            check("R5 prog model", prog_cnt, m_prog);
            check("R6 mode model", mode_word, m_mode);
            check("R9 synth_en model", synth_en, m_mode[0] & (pwr_a | pwr_b));
            check("R10 rx_en model", rx_en, m_mode[0] & pwr_a & ~pwr_b);
            check("R10 tx_en model", tx_en, m_mode[0] & ~pwr_a & pwr_b);
            check("R13 ser_out model", ser_out, mq[0]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); ser_dat = bits[i]; ser_clk = 1'b0;
            @(negedge clk); ser_clk = 1'b1;
            @(negedge clk); ser_clk = 1'b0;
        end
    endtask

    task automatic strobe();
        @(negedge clk); lat_en = 1'b1;
        repeat (3) @(negedge clk);
        lat_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_word(input logic [19:0] w);
        send_bits({12'd0, w}, 20);
        strobe();
    endtask

    initial begin
        logic [19:0] w_long;
        logic [19:0] w_short;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 ref_div reset", ref_div, 0);
        check("R12 mode reset", mode_word, 0);
        check("R12 ser_out reset", ser_out, 0);
        check("R12 synth_en reset", synth_en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R13, R3: shift a reference word; no transfer before the strobe
        send_bits({12'd0, 3'b101, 15'h1234, 2'b00}, 20);
        check("R13 ser_out first bit", ser_out, 1);
        check("R3 ref_div before strobe", ref_div, 0);
        strobe();
        check("R4 ref_div load", ref_div, 15'h1234);

        // R5: main divider
        write_word({11'h4A3, 7'h55, 2'b10});
        check("R5 swallow load", swallow_cnt, 7'h55);
        check("R5 prog load", prog_cnt, 11'h4A3);

        // R6, R9, R10: mode word with enable set, all pin combinations
        write_word({18'h2A5C5, 2'b01});
        check("R6 mode load", mode_word, 18'h2A5C5);
        for (int p = 0; p < 4; p++) begin
            @(negedge clk); pwr_a = p[0]; pwr_b = p[1];
            #1;
            check("R9 synth_en pins", synth_en, (p != 0));
            check("R10 rx_en pins", rx_en, (p == 1));
            check("R10 tx_en pins", tx_en, (p == 2));
        end

        // R7: address 11 discarded
        write_word({18'h3FFFF, 2'b11});
        check("R7 ref kept", ref_div, 15'h1234);
        check("R7 main kept", prog_cnt, 11'h4A3);
        check("R7 mode kept", mode_word, 18'h2A5C5);

        // R2: serial edges with strobe high are ignored; bare strobe reloads old word
        write_word({3'b000, 15'h0777, 2'b00});
        @(negedge clk); lat_en = 1'b1;
        send_bits({12'd0, 20'h0F0F0}, 20);
        lat_en = 1'b0;
        strobe();
        check("R2 ref after high-strobe clocks", ref_div, 15'h0777);

        // R8: long word, last 20 bits count
        w_long = {3'b000, 15'h0ABC, 2'b00};
        send_bits({8'd0, 4'b1111, w_long}, 24);
        strobe();
        check("R8 long word ref", ref_div, 15'h0ABC);
        // R8: short word reuses older bits
        w_short = {w_long[15:0], 4'b0110};
        send_bits(32'h6, 4);
        strobe();
        check("R8 short word swallow", swallow_cnt, w_short[8:2]);
        check("R8 short word prog", prog_cnt, w_short[19:9]);

        // R11: disable, write while disabled, re-enable; contents kept
        write_word({18'h00000, 2'b01});
        @(negedge clk); pwr_a = 1'b1; pwr_b = 1'b0; #1;
        check("R11 synth off", synth_en, 0);
        write_word({3'b000, 15'h5A5A, 2'b00});
        check("R11 write while off", ref_div, 15'h5A5A);
        write_word({18'h00001, 2'b01});
        check("R11 ref kept on wake", ref_div, 15'h5A5A);
        check("R11 prog kept on wake", prog_cnt, w_short[19:9]);
        check("R11 rx on wake", rx_en, 1);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule